// File: doc/BRIEF.md
# Host Stall Watchdog

This block watches a host controller that drives a channel command register over a serial link. When the host stops toggling a dedicated kick pin, the block emits a one-cycle internal reset, which the surrounding logic uses to clear the channel command register. A flag records that an expiry has happened. The host restarts the timer by pulling the kick pin low for a short time. The restart happens on the rising edge that ends that low pulse.

The watchdog only runs when two conditions hold: the serial interface mode is selected, and the enable input is asserted. In the analog world the enable is a voltage compared against a quarter of the logic supply, and the timeout comes from the same voltage. Here that measurement is modelled as a digital enable plus a 2-bit timeout code. The code picks one of four timeout lengths: `BASE_CYCLES`, 4×, 16× or 64× that value. With the default of 16 this gives 16, 64, 256 or 1024 cycles.

The controller is a four-state machine:
- IDLE: disabled.
- ARMED: counting with no expiry seen yet.
- FIRE: the one cycle in which the reset pulse is driven.
- TRIPPED: counting after an expiry.

Its transitions are:
- IDLE to ARMED when enabled.
- ARMED to FIRE on timeout.
- FIRE to TRIPPED, or FIRE to ARMED if a kick lands in that cycle.
- TRIPPED to FIRE on a further timeout.
- TRIPPED to ARMED on a kick.
- Any state to IDLE when disabled.

Top module: `host_stall_watchdog`

## Requirements
- R1: While `rst_ni` is low, `wd_reset_o` and `expired_o` are 0. The kick synchroniser resets to the idle-high level, so releasing reset is never seen as a kick.
- R2: When `serial_mode_i` or `wd_enable_i` is 0 at a rising edge, both outputs are 0 in the following cycle, for as long as the condition lasts.
- R3: The timeout code `tmo_sel_i` maps as follows: code 0 gives L = BASE_CYCLES, 1 gives 4·BASE_CYCLES, 2 gives 16·BASE_CYCLES, and 3 gives 64·BASE_CYCLES. After a restart at rising edge E, `wd_reset_o` is high in the cycle that follows edge E+L, unless another restart intervenes.
- R4: `wd_reset_o` is high for exactly one cycle. The counter then restarts from zero, so uninterrupted pulses come L+1 edges apart.
- R5: A kick is a rising edge on `kick_ni` after at least one rising edge has sampled it low. If edge k is the first to sample the pin high, the restart takes effect at edge k+2.
- R6: A change of `tmo_sel_i` between two consecutive rising edges restarts the counter at the second of them. It does not clear `expired_o`.
- R7: `expired_o` rises in the same cycle as a reset pulse. It stays high through later pulses until a kick restart or a disable.
- R8: The first edge that samples the watchdog as enabled counts as a restart, so counting starts from zero.
- R9: Holding `kick_ni` low, with no rising edge, does not restart the timer. The watchdog still expires.
- R10: A disable clears the counter and `expired_o`. After the disable, timing restarts from zero per R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_mode_i | input | 1 | High when the serial interface mode is selected |
| wd_enable_i | input | 1 | Watchdog enable (digitised enable level) |
| tmo_sel_i | input | 2 | Timeout code (R3) |
| kick_ni | input | 1 | Kick pin, idle high, restarts on end of low pulse |
| wd_reset_o | output | 1 | One-cycle internal reset pulse |
| expired_o | output | 1 | Expiry flag |

## Verification
Every result has a fixed latency, measured in rising edges after the edge that samples the stimulus:
- A disable or an enable takes effect one edge later.
- A code change restarts the counter at the edge that samples it.
- A kick restarts the counter two edges after its rising level is first sampled.
- A pulse follows L edges after the restart.

The bench drives inputs on falling edges. A behavioural model advances on each rising edge, using plain integers and a short history of kick samples. Both outputs are compared against the model on every falling edge, so each delay above is checked in exactly the cycle in which it is due.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_FIRE    = 2'd2,
        WD_TRIPPED = 2'd3
    } wd_state_e;

    // Timeout length in cycles for a 2-bit code: base * 4^code.
    function automatic int unsigned wd_limit(input int unsigned base, input logic [1:0] code);
        return base << (2 * int'(code));
    endfunction

endpackage

// File: rtl/wd_kick_sync.sv
module wd_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_ni,
    output logic kick_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], kick_ni};
            last_q <= sync_q[STAGES-1];
        end
    end

    // End of a low pulse: synchronised level went from low to high.
    assign kick_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
    parameter int unsigned BASE_CYCLES = 16,
    parameter int          CNT_W       = 10
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       term_o
);
    import wdog_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_v;

    always_comb last_v = CNT_W'(wd_limit(BASE_CYCLES, sel_i) - 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign term_o = (cnt_q == last_v);
endmodule

// File: rtl/wd_ctrl.sv
module wd_ctrl (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       active_i,
    input  logic       kick_i,
    input  logic [1:0] sel_i,
    input  logic       term_i,
    output logic       cnt_clr_o,
    output logic       wd_reset_o,
    output logic       expired_o
);
    import wdog_pkg::*;

    wd_state_e  state_q, state_d;
    logic [1:0] sel_q;
    logic       sel_chg;

    assign sel_chg = (sel_i != sel_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WD_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:    state_d = WD_ARMED;
            WD_ARMED:   if (!kick_i && !sel_chg && term_i) state_d = WD_FIRE;
            WD_FIRE:    state_d = kick_i ? WD_ARMED : WD_TRIPPED;
            WD_TRIPPED: begin
                if (kick_i)                     state_d = WD_ARMED;
                else if (!sel_chg && term_i)    state_d = WD_FIRE;
            end
            default:    state_d = WD_IDLE;
        endcase
        if (!active_i) state_d = WD_IDLE;
    end

    always_comb begin
        wd_reset_o = (state_q == WD_FIRE);
        expired_o  = (state_q == WD_FIRE) || (state_q == WD_TRIPPED);
        cnt_clr_o  = !active_i || (state_q == WD_IDLE) || (state_q == WD_FIRE)
                     || kick_i || sel_chg || term_i;
    end
endmodule

// File: rtl/host_stall_watchdog.sv
module host_stall_watchdog #(
    parameter int unsigned BASE_CYCLES = 16,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       serial_mode_i,
    input  logic       wd_enable_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       kick_ni,
    output logic       wd_reset_o,
    output logic       expired_o
);
    localparam int CNT_W = $clog2(BASE_CYCLES * 64);

    logic active, kick, cnt_clr, term;

    assign active = serial_mode_i & wd_enable_i;

    wd_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .kick_ni(kick_ni), .kick_o(kick)
    );

    wd_timer #(.BASE_CYCLES(BASE_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .sel_i(tmo_sel_i), .term_o(term)
    );

    wd_ctrl u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .kick_i(kick),
        .sel_i(tmo_sel_i), .term_i(term), .cnt_clr_o(cnt_clr),
        .wd_reset_o(wd_reset_o), .expired_o(expired_o)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       serial_mode_i,
    input logic       wd_enable_i,
    input logic [1:0] tmo_sel_i,
    input logic       kick_ni,
    input logic       wd_reset_o,
    input logic       expired_o
);
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_reset_o |=> !wd_reset_o);

    a_r7_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_reset_o |-> expired_o);

    a_r7_flag_rises_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(expired_o) |-> wd_reset_o);

    a_r2_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(serial_mode_i && wd_enable_i) |=> (!wd_reset_o && !expired_o));

    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |-> (!wd_reset_o && !expired_o));
endmodule

bind host_stall_watchdog wdog_checker u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .serial_mode_i(serial_mode_i),
    .wd_enable_i(wd_enable_i), .tmo_sel_i(tmo_sel_i), .kick_ni(kick_ni),
    .wd_reset_o(wd_reset_o), .expired_o(expired_o)
);

// File: tb/host_stall_watchdog_bench.sv
module host_stall_watchdog_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       kick_n = 1'b1;
    logic       wd_reset, expired;

    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    host_stall_watchdog u_host_stall_watchdog (
        .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(serial), .wd_enable_i(en),
        .tmo_sel_i(sel), .kick_ni(kick_n), .wd_reset_o(wd_reset), .expired_o(expired)
    );

    // Behavioural reference model
    int unsigned m_cnt = 0;
    bit m_on = 0, m_pulse = 0, m_exp = 0;
    bit h1 = 1, h2 = 1, h3 = 1;
    logic [1:0] m_last_sel = 2'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_on = 0; m_pulse = 0; m_exp = 0;
            h1 = 1; h2 = 1; h3 = 1; m_last_sel = 2'd0;
        end else begin
            bit kick_seen;
            bit chg;
            int unsigned lim;
            kick_seen = h2 && !h3;
            chg       = (sel != m_last_sel);
            lim       = 16 * (4 ** sel);
            if (!(serial && en)) begin
                m_on = 0; m_cnt = 0; m_pulse = 0; m_exp = 0;
            end else if (!m_on) begin
                m_on = 1; m_cnt = 0; m_pulse = 0; m_exp = 0;
            end else if (m_pulse) begin
                m_pulse = 0; m_cnt = 0;
                if (kick_seen) m_exp = 0;
            end else if (kick_seen) begin
                m_cnt = 0; m_exp = 0;
            end else if (chg) begin
                m_cnt = 0;
            end else if (m_cnt == lim - 1) begin
                m_cnt = 0; m_pulse = 1; m_exp = 1;
            end else begin
                m_cnt++;
            end
            h3 = h2; h2 = h1; h1 = kick_n;
            m_last_sel = sel;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            vectors++;
            if (wd_reset !== m_pulse) begin
                fails++;
                $display("FAIL %s wd_reset_o got %b expected %b at %0t", cur_req, wd_reset, m_pulse, $time);
            end
            vectors++;
            if (expired !== m_exp) begin
                fails++;
                $display("FAIL %s expired_o got %b expected %b at %0t", cur_req, expired, m_exp, $time);
            end
        end
    endtask

    task automatic kick(input int low_cycles);
        kick_n = 1'b0;
        tick(low_cycles);
        kick_n = 1'b1;
    endtask

    initial begin
        // R1: outputs quiet during reset
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R2: enable low, then serial mode low
        cur_req = "R2";
        serial = 1'b1; en = 1'b0;
        tick(60);
        serial = 1'b0; en = 1'b1;
        tick(60);
        // R8/R3/R4: start counting with code 0, several pulses
        cur_req = "R8";
        serial = 1'b1;
        tick(20);
        cur_req = "R4";
        tick(80);
        // R5/R7: kick clears expiry flag
        cur_req = "R5";
        kick(2);
        tick(40);
        cur_req = "R7";
        tick(60);
        // R5: regular kicks keep it quiet
        cur_req = "R5";
        for (int k = 0; k < 10; k++) begin
            kick(1);
            tick(9);
        end
        // R9: pin held low never restarts
        cur_req = "R9";
        kick_n = 1'b0;
        tick(60);
        kick_n = 1'b1;
        tick(10);
        // R6: code changes restart the counter
        cur_req = "R6";
        for (int k = 0; k < 8; k++) begin
            sel = (k % 2 == 0) ? 2'd1 : 2'd0;
            tick(12);
        end
        // R3: each longer code
        cur_req = "R3";
        sel = 2'd1; tick(150);
        sel = 2'd2; tick(600);
        sel = 2'd3; tick(2200);
        // R10: disable while expired, then re-enable
        cur_req = "R10";
        sel = 2'd0; tick(40);
        en = 1'b0; tick(5);
        en = 1'b1; tick(40);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete, got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule